// File: doc/BRIEF.md
# Prioritized Multi-Source Interrupt Controller

This block collects interrupt requests from three kinds of source and presents one winning request to a processor core. A non-maskable reset-class source always takes part. A set of external pins each has its own enable bit and a two-bit trigger-mode field, so each pin can request on a low level, on a falling edge or on a rising edge. A set of internal sources has no individual enable. Each internal source latches a pending flag from a set pulse, and software clears that flag with a clear strobe.

A single global enable bit gates every source except the reset-class one. Requests that arrive together are resolved by fixed vector number, and the lowest number wins. When the core accepts, the block registers the winning vector number and its handler address, which is the relocatable table base plus four bytes per vector slot. Acceptance also drops the global bit. A return strobe raises the global bit again, and two further strobes let software set or clear it directly. Setting the bit inside a handler lets a new request nest.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, `irq`, `gie`, `vec_num` and `vec_addr` are all zero.
- R2: The global bit updates on the clock edge. An honoured accept clears it, and this overrides every other strobe. Otherwise `gie_clr` clears it, and this overrides `gie_set`. Otherwise `gie_set` or `reti` sets it.
- R3: An honoured accept loads `vec_num` and `vec_addr` from the current winner on that edge. Both outputs then hold until the next honoured accept.
- R4: An accept is honoured only in a cycle where `irq` is high. An accept while `irq` is low changes neither vector output nor the global bit.
- R5: A pulse on `int_set[j]` latches the internal flag j. A pulse on `int_clr[j]` clears it, and set wins when both arrive together. Acceptance does not clear the flag. The flag requests whenever the global bit is set.
- R6: External pin i requests only when `ext_en[i]` is 1 and the global bit is 1.
- R7: The mode field of pin i is `ext_mode[2i+1:2i]`. Code 00 is low level, and the pin requests in every cycle it is low with nothing latched. Code 10 is falling edge and code 11 is rising edge. Both edges are judged against the pin value at the previous clock edge. Code 01 never requests and clears the latched flag.
- R8: A detected edge latches the pin flag even while the pin's enable is 0. The flag clears when its own vector is accepted. A new edge in the same cycle keeps the flag set.
- R9: Vector numbers are assigned as follows: 1 is the reset-class source; 2 through N_EXT+1 are pins 0 upward; the internal sources 0 upward follow these. Among active requests the lowest number wins.
- R10: The reset-class source latches on `rst_src`, requests regardless of the global bit, and clears when vector 1 is accepted.
- R11: On an honoured accept, `vec_addr` equals `tbl_base` at that edge plus 4*(vector number - 1), so vector 1 sits at the base itself.
- R12: `irq` is high in the same cycle that any request passes its mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | N_EXT | External request pins, synchronous to clk |
| ext_en | input | N_EXT | Per-pin enable |
| ext_mode | input | 2*N_EXT | Per-pin trigger-mode fields, two bits per pin |
| int_set | input | N_INT | Internal source set pulses |
| int_clr | input | N_INT | Internal source clear strobes |
| rst_src | input | 1 | Reset-class request pulse |
| gie_set | input | 1 | Set-global-enable strobe |
| gie_clr | input | 1 | Clear-global-enable strobe |
| accept | input | 1 | Core accepts the current winner |
| reti | input | 1 | Return-from-handler strobe |
| tbl_base | input | AW | Vector table base address |
| irq | output | 1 | Interrupt request to the core |
| vec_num | output | VW | Registered accepted vector number |
| vec_addr | output | AW | Registered accepted handler address |
| gie | output | 1 | Global enable bit |

## Verification
The assertions assume that every strobe and the external pins are already synchronous to the clock. Each strobe is treated as a one-cycle sample, and `tbl_base` is read only on the accept edge. The bench changes all inputs half a period away from the active edge, so every sample falls between edges. Strobes are raised for exactly one cycle, and pins stay high through reset so that no edge appears before the first model step. The random phase leaves strobe collisions in place on purpose, such as set against clear and accept against return, because the requirements define the winner in each case.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_OFF  = 2'b01,
    TRIG_FALL = 2'b10,
    TRIG_RISE = 2'b11
  } trig_e;

  // each vector slot spans 1 << SLOT_SHIFT bytes
  localparam int SLOT_SHIFT = 2;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/irq_flag.sv
module irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  logic q_d;
  logic q_r;

  always_comb begin
    q_d = q_r;
    if (clr) q_d = 1'b0;
    if (set) q_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= 1'b0;
    else        q_r <= q_d;
  end

  assign q = q_r;
endmodule

// File: rtl/irq_pin_cond.sv
module irq_pin_cond
  import irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic [1:0] mode,
  input  logic       en,
  input  logic       acc_clr,
  output logic       req
);
  trig_e mode_e;
  logic  pin_q;
  logic  flag_q;
  logic  flag_d;
  logic  edge_hit;

  assign mode_e = trig_e'(mode);

  always_comb begin
    edge_hit = 1'b0;
    case (mode_e)
      TRIG_FALL: edge_hit = pin_q & ~pin;
      TRIG_RISE: edge_hit = ~pin_q & pin;
      default:   edge_hit = 1'b0;
    endcase

    flag_d = flag_q;
    if (acc_clr || !mode[1]) flag_d = 1'b0;
    if (edge_hit)            flag_d = 1'b1;

    case (mode_e)
      TRIG_LOW:             req = en & ~pin;
      TRIG_FALL, TRIG_RISE: req = en & flag_q;
      default:              req = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q  <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      pin_q  <= pin;
      flag_q <= flag_d;
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N  = 11,
  parameter int VW = 4
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [VW-1:0] num
);
  always_comb begin
    any = 1'b0;
    num = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req[k]) begin
        any = 1'b1;
        num = VW'(k + 1);
      end
    end
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int N_EXT = 4,
  parameter int N_INT = 6,
  parameter int AW    = 16,
  localparam int N_VEC = 1 + N_EXT + N_INT,
  localparam int VW    = $clog2(N_VEC + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_EXT-1:0]   ext_pin,
  input  logic [N_EXT-1:0]   ext_en,
  input  logic [2*N_EXT-1:0] ext_mode,
  input  logic [N_INT-1:0]   int_set,
  input  logic [N_INT-1:0]   int_clr,
  input  logic               rst_src,
  input  logic               gie_set,
  input  logic               gie_clr,
  input  logic               accept,
  input  logic               reti,
  input  logic [AW-1:0]      tbl_base,
  output logic               irq,
  output logic [VW-1:0]      vec_num,
  output logic [AW-1:0]      vec_addr,
  output logic               gie
);
  localparam int EXT_LO = 1;
  localparam int INT_LO = 1 + N_EXT;
  localparam int NCLR   = N_EXT + 1;

  logic            rst_ns;
  logic [N_VEC-1:0] req;
  logic [N_VEC-1:0] masked;
  logic [NCLR-1:0]  acc_clr;
  logic             any;
  logic [VW-1:0]    win_num;
  logic             acc_ok;
  logic             gie_q, gie_d;
  logic [VW-1:0]    vnum_q;
  logic [AW-1:0]    vaddr_q, vaddr_d;

  irq_rst_sync #(.STAGES(2)) u_rsync (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ns)
  );

  // vector 1: non-maskable reset-class source
  irq_flag u_rst_flag (
    .clk(clk), .rst_n(rst_ns), .set(rst_src), .clr(acc_clr[0]), .q(req[0])
  );

  for (genvar g = 0; g < N_EXT; g++) begin : g_pin
    irq_pin_cond u_pin (
      .clk    (clk),
      .rst_n  (rst_ns),
      .pin    (ext_pin[g]),
      .mode   (ext_mode[2*g +: 2]),
      .en     (ext_en[g]),
      .acc_clr(acc_clr[EXT_LO + g]),
      .req    (req[EXT_LO + g])
    );
  end

  for (genvar g = 0; g < N_INT; g++) begin : g_int
    irq_flag u_int_flag (
      .clk(clk), .rst_n(rst_ns), .set(int_set[g]), .clr(int_clr[g]),
      .q(req[INT_LO + g])
    );
  end

  always_comb begin
    masked    = req & {{(N_VEC - 1){gie_q}}, 1'b1};
  end

  irq_prio_enc #(.N(N_VEC), .VW(VW)) u_enc (
    .req(masked), .any(any), .num(win_num)
  );

  always_comb begin
    acc_ok  = accept & any;
    acc_clr = acc_ok ? (NCLR'(1) << (win_num - VW'(1))) : '0;
    vaddr_d = tbl_base + ((AW'(win_num) - AW'(1)) << SLOT_SHIFT);
    gie_d   = gie_q;
    if (gie_set || reti) gie_d = 1'b1;
    if (gie_clr)         gie_d = 1'b0;
    if (acc_ok)          gie_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      gie_q   <= 1'b0;
      vnum_q  <= '0;
      vaddr_q <= '0;
    end else begin
      gie_q <= gie_d;
      if (acc_ok) begin
        vnum_q  <= win_num;
        vaddr_q <= vaddr_d;
      end
    end
  end

  assign irq      = any;
  assign vec_num  = vnum_q;
  assign vec_addr = vaddr_q;
  assign gie      = gie_q;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int N_EXT = 4,
  parameter int N_INT = 6,
  parameter int AW    = 16,
  localparam int N_VEC = 1 + N_EXT + N_INT,
  localparam int VW    = $clog2(N_VEC + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          gie_set,
  input logic          gie_clr,
  input logic          accept,
  input logic          reti,
  input logic [AW-1:0] tbl_base,
  input logic          irq,
  input logic [VW-1:0] vec_num,
  input logic [AW-1:0] vec_addr,
  input logic          gie
);
  // R2
  acc_drops_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && irq) |=> !gie);
  // R2
  set_raises_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((gie_set || reti) && !gie_clr && !(accept && irq)) |=> gie);
  // R2
  clr_wins_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gie_clr |=> !gie);
  // R3
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && irq) |=> ($stable(vec_num) && $stable(vec_addr)));
  // R4
  acc_ignored_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !irq && !gie_set && !gie_clr && !reti) |=> $stable(gie));
  // R9
  vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && irq) |=> (vec_num != '0 && int'(vec_num) <= N_VEC));
  // R11
  vec_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && irq) |=>
      (vec_addr == AW'($past(tbl_base) + AW'((int'(vec_num) - 1) * 4))));
endmodule

bind irq_ctrl irq_ctrl_chk #(.N_EXT(N_EXT), .N_INT(N_INT), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_ns), .gie_set(gie_set), .gie_clr(gie_clr),
  .accept(accept), .reti(reti), .tbl_base(tbl_base), .irq(irq),
  .vec_num(vec_num), .vec_addr(vec_addr), .gie(gie)
);

// File: tb/irq_ctrl_bench.sv
module irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 4;
  localparam int NI = 6;
  localparam int AW = 16;
  localparam int NV = 1 + NE + NI;
  localparam int VW = $clog2(NV + 1);

  logic clk = 1'b0;
  logic rst_n;
  logic [NE-1:0]   ext_pin;
  logic [NE-1:0]   ext_en;
  logic [2*NE-1:0] ext_mode;
  logic [NI-1:0]   int_set, int_clr;
  logic rst_src, gie_set, gie_clr, accept, reti;
  logic [AW-1:0]   tbl_base;
  logic            irq, gie;
  logic [VW-1:0]   vec_num;
  logic [AW-1:0]   vec_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // reference model state
  int m_gie, m_rst, m_num, m_addr;
  int m_ef[NE];
  int m_pp[NE];
  int m_if[NI];

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_ctrl #(.N_EXT(NE), .N_INT(NI), .AW(AW)) u_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .ext_en(ext_en),
    .ext_mode(ext_mode), .int_set(int_set), .int_clr(int_clr),
    .rst_src(rst_src), .gie_set(gie_set), .gie_clr(gie_clr),
    .accept(accept), .reti(reti), .tbl_base(tbl_base), .irq(irq),
    .vec_num(vec_num), .vec_addr(vec_addr), .gie(gie)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int mode_of(int i);
    return int'(ext_mode[2*i +: 2]);
  endfunction

  function automatic int model_req(int v);
    int i, md;
    if (v == 1) return m_rst;
    if (v <= NE + 1) begin
      i = v - 2;
      md = mode_of(i);
      if (!ext_en[i]) return 0;
      if (md == 0) return ext_pin[i] ? 0 : 1;
      if (md >= 2) return m_ef[i];
      return 0;
    end
    return m_if[v - 2 - NE];
  endfunction

  function automatic int model_win();
    int w = 0;
    for (int v = NV; v >= 1; v--)
      if (model_req(v) != 0 && (v == 1 || m_gie != 0)) w = v;
    return w;
  endfunction

  task automatic model_reset();
    m_gie = 0; m_rst = 0; m_num = 0; m_addr = 0;
    for (int i = 0; i < NE; i++) begin m_ef[i] = 0; m_pp[i] = 1; end
    for (int j = 0; j < NI; j++) m_if[j] = 0;
  endtask

  task automatic clear_strobes();
    int_set = '0; int_clr = '0; rst_src = 0; gie_set = 0;
    gie_clr = 0; accept = 0; reti = 0;
  endtask

  // inputs are already applied; compare, advance the model, pass one edge
  task automatic tick();
    int w, acc, md, ed;
    #1;
    w = model_win();
    chk("R12 irq", int'(irq), (w != 0) ? 1 : 0);
    chk("R2 gie", int'(gie), m_gie);
    chk("R3 vec_num", int'(vec_num), m_num);
    chk("R11 vec_addr", int'(vec_addr), m_addr);
    acc = (accept && w != 0) ? 1 : 0;
    if (acc != 0) begin
      m_num  = w;
      m_addr = (int'(tbl_base) + 4 * (w - 1)) % (1 << AW);
      m_gie  = 0;
    end else if (gie_clr) m_gie = 0;
    else if (gie_set || reti) m_gie = 1;
    if (rst_src) m_rst = 1;
    else if (acc != 0 && w == 1) m_rst = 0;
    for (int i = 0; i < NE; i++) begin
      md = mode_of(i);
      ed = ((md == 2 && m_pp[i] != 0 && !ext_pin[i]) ||
            (md == 3 && m_pp[i] == 0 && ext_pin[i])) ? 1 : 0;
      if (ed != 0) m_ef[i] = 1;
      else if (md < 2 || (acc != 0 && w == i + 2)) m_ef[i] = 0;
      m_pp[i] = ext_pin[i] ? 1 : 0;
    end
    for (int j = 0; j < NI; j++) begin
      if (int_set[j]) m_if[j] = 1;
      else if (int_clr[j]) m_if[j] = 0;
    end
    @(posedge clk);
    @(negedge clk);
    clear_strobes();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    ext_pin = '1; ext_en = '0; ext_mode = '0; tbl_base = '0;
    clear_strobes();
    model_reset();
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 irq", int'(irq), 0);
    chk("R1 gie", int'(gie), 0);
    chk("R1 vec_num", int'(vec_num), 0);
    chk("R1 vec_addr", int'(vec_addr), 0);
    repeat (3) tick();

    // R5: internal flag waits for global bit
    int_set[2] = 1; tick();
    chk("R5 masked", int'(irq), 0);
    gie_set = 1; tick();
    chk("R5 unmasked", int'(irq), 1);
    accept = 1; tick();
    chk("R3 vec_num", int'(vec_num), 2 + NE + 2);
    chk("R11 vec_addr", int'(vec_addr), 4 * (1 + NE + 2));
    chk("R2 acc clears gie", int'(gie), 0);
    // R4: accept with irq low is ignored
    accept = 1; tick();
    chk("R4 vec_num held", int'(vec_num), 2 + NE + 2);
    chk("R4 gie held", int'(gie), 0);
    reti = 1; tick();
    chk("R5 flag survives accept", int'(irq), 1);
    int_clr[2] = 1; tick();
    chk("R5 clear strobe", int'(irq), 0);

    // R6 / R8: rising edge on pin 0 latched while disabled
    ext_mode[1:0] = 2'b11; ext_pin[0] = 0; tick();
    ext_pin[0] = 1; tick();
    chk("R6 disabled pin", int'(irq), 0);
    ext_en[0] = 1; tick();
    chk("R8 latched while disabled", int'(irq), 1);
    accept = 1; tick();
    chk("R9 pin0 vector", int'(vec_num), 2);
    reti = 1; tick();
    chk("R8 flag cleared by accept", int'(irq), 0);

    // R7: low level on pin 1
    ext_mode[3:2] = 2'b00; ext_en[1] = 1; ext_pin[1] = 0; tick();
    chk("R7 level low", int'(irq), 1);
    ext_pin[1] = 1; tick();
    chk("R7 level not latched", int'(irq), 0);

    // R7: falling edge on pin 2
    ext_mode[5:4] = 2'b10; ext_en[2] = 1; ext_pin[2] = 0; tick();
    chk("R7 falling edge", int'(irq), 1);
    accept = 1; tick();
    chk("R7 falling vector", int'(vec_num), 4);
    reti = 1; tick();
    chk("R7 falling cleared", int'(irq), 0);

    // R7: reserved code on pin 3
    ext_mode[7:6] = 2'b01; ext_en[3] = 1; ext_pin[3] = 0; tick();
    ext_pin[3] = 1; tick();
    chk("R7 reserved code", int'(irq), 0);

    // R10 / R11: non-maskable source with relocated base
    gie_clr = 1; tick();
    rst_src = 1; int_set[0] = 1; tick();
    chk("R10 ignores global bit", int'(irq), 1);
    tbl_base = 16'h1000; accept = 1; tick();
    chk("R10 vector one", int'(vec_num), 1);
    chk("R11 base address", int'(vec_addr), 16'h1000);
    chk("R10 cleared by accept", int'(irq), 0);

    // R9: pin 1 level beats internal 0
    gie_set = 1; ext_pin[1] = 0; tick();
    accept = 1; tick();
    chk("R9 lowest wins", int'(vec_num), 3);
    chk("R11 slot offset", int'(vec_addr), 16'h1008);

    // R2: nesting, then clear beats set
    gie_set = 1; tick();
    chk("R2 nested irq", int'(irq), 1);
    ext_pin[1] = 1; accept = 1; tick();
    chk("R9 internal vector", int'(vec_num), 2 + NE);
    gie_set = 1; gie_clr = 1; tick();
    chk("R2 clear beats set", int'(gie), 0);

    // random phase against the model
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(0, 7) == 0) ext_pin[$urandom_range(0, NE - 1)] ^= 1'b1;
      if ($urandom_range(0, 31) == 0) ext_mode = 8'($urandom);
      if ($urandom_range(0, 31) == 0) ext_en = 4'($urandom);
      if ($urandom_range(0, 15) == 0) int_set = 6'(1 << $urandom_range(0, NI - 1));
      if ($urandom_range(0, 15) == 0) int_clr = 6'(1 << $urandom_range(0, NI - 1));
      rst_src = ($urandom_range(0, 63) == 0);
      gie_set = ($urandom_range(0, 7) == 0);
      gie_clr = ($urandom_range(0, 15) == 0);
      reti    = ($urandom_range(0, 7) == 0);
      accept  = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 63) == 0) tbl_base = 16'($urandom);
      tick();
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule